// File: doc/BRIEF.md
# Capture Timer with Auxiliary PWM

This block is built around a free-running time-stamp counter that serves one of two functions, chosen by a mode bit. In capture mode the shared pin is an input, and each rising edge on it records the counter value into a ring of four capture registers. In PWM mode the pin becomes an output. The counter then wraps at a programmable period, and the output level is derived from a compare value. Both the period and the compare value are double-buffered, so software writes take effect only at a period boundary.

The counter can be frozen, or loaded from a phase register when a sync event arrives. A sync event is either a pulse on `sync_in` or a software force. A selectable `sync_out` lets several instances be chained into a synchronised group: the next instance's `sync_in` is wired to this instance's `sync_out`.

Software reaches the block through a plain register port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `rd_addr`. The port has no handshake: every write is accepted in its cycle, so there is no back-pressure.

**Register map (word addresses):**

| Address | Contents |
|---|---|
| 0 | Control register |
| 1 | Phase |
| 2 | Period (shadow) |
| 3 | Compare (shadow) |
| 4 | Counter (read only) |
| 8 to 11 | Capture slots 0 to 3 |

**Control register bits:**

| Bit(s) | Function |
|---|---|
| [0] | Run |
| [1] | Sync enable |
| [3:2] | Sync-out select |
| [4] | Software sync, write-one pulse |
| [5] | Mode: 0 = capture, 1 = PWM |
| [6] | Output polarity |

Top module: `cap_tmr_top`

## Requirements
- R1: After reset, every control field is 0. The control register reads 0, the counter reads 0 and `pin_oe` is 0.
- R2: With run (control bit 0) at 0, the counter holds its value. With run at 1, it advances by exactly one per clock.
- R3: `pin_oe` follows the mode bit (control bit 5): 0 selects capture mode with the pin as an input, and 1 selects PWM mode with the pin driven.
- R4: In PWM mode the counter returns to 0 on the edge after it equals the active period (the period-equal event). In capture mode it counts past the period value.
- R5: In PWM mode the shadow period and compare values (addresses 2 and 3) move into the active registers on the period-equal event. In capture mode the active registers keep their values.
- R6: In PWM mode, with polarity (control bit 6) at 0, `pin_out` is high exactly while counter < active compare. With polarity at 1 the output is inverted.
- R7: In capture mode, each rising edge of `pin_in` stores the counter value of that cycle into capture slots 0, 1, 2, 3, 0, … in turn. In PWM mode nothing is captured.
- R8: With sync enable (control bit 1) at 1, a `sync_in` pulse loads the phase register into the counter on the next edge. With sync enable at 0, `sync_in` leaves the counter unchanged.
- R9: Writing 1 to control bit 4 makes a one-cycle software sync in the cycle after the write. That pulse phase-loads the counter when sync enable is 1, and also appears on `sync_out` under pass-through. Bit 4 always reads 0.
- R10: Sync-out select (control bits 3:2) works as follows:
  - 00 drives `sync_out` with `sync_in` OR the software sync.
  - 01 drives the period-equal event.
  - 10 and 11 hold `sync_out` low.
- R11: When a phase load and a period-equal reset fall on the same edge, the phase load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| sync_in | input | 1 | Sync pulse from the upstream instance |
| sync_out | output | 1 | Sync pulse to the downstream instance |
| pin_in | input | 1 | Capture input |
| pin_out | output | 1 | PWM output |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
The embedded assertions check the counter's step, freeze, wrap and phase-load behaviour on every cycle, together with phase-load priority. They also check that the active period and the capture pointer stay still in the mode where they must not move. Only the bench scenarios can show the following:
- the round-robin order and the exact values captured;
- the PWM duty and polarity as seen on the pin;
- that shadow values are adopted only at a period boundary;
- the effect of each sync-out selection on a downstream chain.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PHASE = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRD   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd4;

  localparam int B_SWSYNC = 4;

  typedef enum logic [1:0] {
    SO_PASS = 2'b00,
    SO_PEQ  = 2'b01,
    SO_OFF0 = 2'b10,
    SO_OFF1 = 2'b11
  } so_sel_e;

  typedef struct packed {
    logic    pol;
    logic    mode;
    so_sel_e so_sel;
    logic    sync_en;
    logic    run;
  } ctrl_t;
endpackage

// File: rtl/cap_tmr_regs.sv
module cap_tmr_regs
  import cap_tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output ctrl_t             ctrl,
  output logic              sw_sync,
  output logic [DW-1:0]     phase,
  output logic [DW-1:0]     prd_sh,
  output logic [DW-1:0]     cmp_sh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      sw_sync <= 1'b0;
      phase   <= '0;
      prd_sh  <= '0;
      cmp_sh  <= '0;
    end else begin
      sw_sync <= wr_en && (wr_addr == A_CTRL) && wr_data[B_SWSYNC];
      if (wr_en) begin
        unique case (wr_addr)
          A_CTRL: begin
            ctrl.run     <= wr_data[0];
            ctrl.sync_en <= wr_data[1];
            ctrl.so_sel  <= so_sel_e'(wr_data[3:2]);
            ctrl.mode    <= wr_data[5];
            ctrl.pol     <= wr_data[6];
          end
          A_PHASE: phase  <= wr_data;
          A_PRD:   prd_sh <= wr_data;
          A_CMP:   cmp_sh <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_tmr_tbase.sv
module cap_tmr_tbase
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             sw_sync,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cnt,
  output logic             prd_eq,
  output logic             sync_out
);
  logic sync_evt;
  logic load;

  assign sync_evt = sync_in | sw_sync;
  assign load     = ctrl.sync_en & sync_evt;
  assign prd_eq   = (cnt == prd_act);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= phase;
    else if (ctrl.mode && prd_eq) cnt <= '0;
    else if (ctrl.run)          cnt <= cnt + 1'b1;
  end

  always_comb begin
    unique case (ctrl.so_sel)
      SO_PASS: sync_out = sync_evt;
      SO_PEQ:  sync_out = prd_eq;
      default: sync_out = 1'b0;
    endcase
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !load && !(ctrl.mode && prd_eq)) |=> $stable(cnt)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !load && !(ctrl.mode && prd_eq)) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(phase)); // R11
  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode && prd_eq && !load) |=> cnt == '0); // R4
endmodule

// File: rtl/cap_tmr_pwm.sv
module cap_tmr_pwm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             pol,
  input  logic             prd_eq,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prd_sh,
  input  logic [CNT_W-1:0] cmp_sh,
  output logic [CNT_W-1:0] prd_act,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act <= '0;
      cmp_act <= '0;
    end else if (mode && prd_eq) begin
      prd_act <= prd_sh;
      cmp_act <= cmp_sh;
    end
  end

  assign pwm_o = mode & ((cnt < cmp_act) ^ pol);

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> ($stable(prd_act) && $stable(cmp_act))); // R5
endmodule

// File: rtl/cap_tmr_capture.sv
module cap_tmr_capture #(
  parameter int CNT_W = 32,
  parameter int NCAP  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode,
  input  logic                  pin_in,
  input  logic [CNT_W-1:0]      cnt,
  output logic [NCAP*CNT_W-1:0] cap_flat
);
  localparam int PTR_W = (NCAP > 1) ? $clog2(NCAP) : 1;

  logic             pin_q;
  logic             rise;
  logic [PTR_W-1:0] ptr;

  assign rise = ~mode & pin_in & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      ptr   <= '0;
    end else begin
      pin_q <= pin_in;
      if (rise) ptr <= (ptr == PTR_W'(NCAP - 1)) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NCAP; g++) begin : g_slot
    logic [CNT_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n)                        slot <= '0;
      else if (rise && ptr == PTR_W'(g)) slot <= cnt;
    end
    assign cap_flat[g*CNT_W +: CNT_W] = slot;
  end

  AST_NO_CAP_IN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> $stable(ptr)); // R7
endmodule

// File: rtl/cap_tmr_top.sv
module cap_tmr_top
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NCAP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              sync_in,
  output logic              sync_out,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int SLOT_W = $clog2(NCAP);

  ctrl_t                  ctrl;
  logic                   sw_sync;
  logic                   prd_eq;
  logic [CNT_W-1:0]       phase;
  logic [CNT_W-1:0]       prd_sh;
  logic [CNT_W-1:0]       cmp_sh;
  logic [CNT_W-1:0]       prd_act;
  logic [CNT_W-1:0]       cnt;
  logic [NCAP*CNT_W-1:0]  cap_flat;

  cap_tmr_regs #(.DW(CNT_W)) i_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .ctrl, .sw_sync, .phase, .prd_sh, .cmp_sh
  );

  cap_tmr_tbase #(.CNT_W(CNT_W)) i_tbase (
    .clk, .rst_n, .ctrl, .sw_sync, .sync_in, .phase, .prd_act,
    .cnt, .prd_eq, .sync_out
  );

  cap_tmr_pwm #(.CNT_W(CNT_W)) i_pwm (
    .clk, .rst_n, .mode(ctrl.mode), .pol(ctrl.pol), .prd_eq, .cnt,
    .prd_sh, .cmp_sh, .prd_act, .pwm_o(pin_out)
  );

  cap_tmr_capture #(.CNT_W(CNT_W), .NCAP(NCAP)) i_cap (
    .clk, .rst_n, .mode(ctrl.mode), .pin_in, .cnt, .cap_flat
  );

  assign pin_oe = ctrl.mode;

  always_comb begin
    rd_data = '0;
    if (rd_addr[3]) begin
      if (32'(rd_addr[2:0]) < NCAP)
        rd_data = cap_flat[32'(rd_addr[SLOT_W-1:0]) * CNT_W +: CNT_W];
    end else begin
      unique case (rd_addr)
        A_CTRL:  rd_data = CNT_W'({ctrl.pol, ctrl.mode, 1'b0, ctrl.so_sel,
                                   ctrl.sync_en, ctrl.run});
        A_PHASE: rd_data = phase;
        A_PRD:   rd_data = prd_sh;
        A_CMP:   rd_data = cmp_sh;
        A_CNT:   rd_data = cnt;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: tb/test_cap_tmr_top.sv
module test_cap_tmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sync_in = 1'b0;
  logic        sync_out;
  logic        pin_in = 1'b0;
  logic        pin_out;
  logic        pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cap_tmr_top i_cap_tmr_top (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .sync_in, .sync_out, .pin_in, .pin_out, .pin_oe
  );

  localparam logic [31:0] C_RUN  = 32'h01;
  localparam logic [31:0] C_SEN  = 32'h02;
  localparam logic [31:0] C_SW   = 32'h10;
  localparam logic [31:0] C_MODE = 32'h20;
  localparam logic [31:0] C_POL  = 32'h40;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    rd(4'd0, v); check("R1 ctrl", v, 0);
    rd(4'd4, v); check("R1 counter", v, 0);
    check("R1 pin_oe", pin_oe, 0);
    repeat (5) @(posedge clk);
    @(negedge clk); rd(4'd4, v); check("R2 frozen", v, 0);
  endtask

  task automatic t_run;
    logic [31:0] a, b;
    wr(4'd0, C_RUN);
    @(negedge clk); rd(4'd4, a);
    repeat (7) @(posedge clk);
    @(negedge clk); rd(4'd4, b);
    check("R2 step", b - a, 7);
    check("R3 capture pin_oe", pin_oe, 0);
  endtask

  task automatic t_capture;
    logic [31:0] c [5];
    logic [31:0] v;
    wr(4'd2, 32'd10);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rd(4'd4, c[i]); pin_in = 1'b1;
      @(negedge clk); pin_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    rd(4'd9, v);  check("R7 slot1", v, c[1]);
    rd(4'd10, v); check("R7 slot2", v, c[2]);
    rd(4'd11, v); check("R7 slot3", v, c[3]);
    rd(4'd8, v);  check("R7 slot0 wrapped", v, c[4]);
    rd(4'd4, v);  check("R4 no wrap in capture", v > 32'd10, 1);
  endtask

  task automatic t_sync;
    logic [31:0] v, a;
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd123);
    @(negedge clk); rd(4'd4, a);
    sync_in = 1'b1; #0.5;
    check("R10 pass-through", sync_out, 1);
    @(posedge clk); #1 sync_in = 1'b0;
    @(negedge clk); rd(4'd4, v); check("R8 ignored", v, a);
    wr(4'd0, C_SEN);
    @(negedge clk); sync_in = 1'b1;
    @(posedge clk); #1 sync_in = 1'b0;
    @(negedge clk); rd(4'd4, v); check("R8 phase load", v, 123);
    wr(4'd0, C_SEN | 32'h08);
    @(negedge clk); sync_in = 1'b1; #0.5;
    check("R10 off", sync_out, 0);
    @(posedge clk); #1 sync_in = 1'b0;
    wr(4'd1, 32'd55);
    wr(4'd0, C_SEN | C_SW);
    #0.5; check("R9 pulse on sync_out", sync_out, 1);
    rd(4'd0, v); check("R9 reads zero", v[4], 0);
    @(negedge clk); rd(4'd4, v); check("R9 sw phase load", v, 55);
  endtask

  task automatic t_pwm;
    logic [31:0] v;
    int mx = 0, bad = 0, wraps = 0;
    wr(4'd1, 32'd0);
    wr(4'd0, C_SEN | C_SW);
    wr(4'd2, 32'd9);
    wr(4'd3, 32'd4);
    wr(4'd0, C_MODE | C_RUN);
    repeat (3) @(negedge clk);
    check("R3 pwm pin_oe", pin_oe, 1);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); rd(4'd4, v);
      if (v > mx) mx = v;
      if (v == 0) wraps++;
      if (pin_out !== (v < 4)) bad++;
    end
    check("R4 max count", mx, 9);
    check("R4 wraps seen", wraps >= 2, 1);
    check("R6 active high", bad, 0);
    wr(4'd0, C_MODE | C_RUN | C_POL);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rd(4'd4, v);
      if (pin_out !== !(v < 4)) bad++;
    end
    check("R6 active low", bad, 0);
  endtask

  task automatic t_shadow;
    logic [31:0] v;
    int bad = 0;
    wr(4'd0, C_MODE | C_RUN);
    wr(4'd3, 32'd7);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rd(4'd4, v);
      if (v == 0) break;
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rd(4'd4, v);
      if (pin_out !== (v < 7)) bad++;
    end
    check("R5 new compare at boundary", bad, 0);
    wr(4'd0, C_MODE | C_RUN | 32'h04);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rd(4'd4, v); #0.5;
      if (sync_out !== (v == 9)) bad++;
    end
    check("R10 period-equal out", bad, 0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(4'd1, 32'd3);
    wr(4'd0, C_MODE | C_RUN | C_SEN);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rd(4'd4, v);
      if (v == 9) break;
    end
    check("R11 reached period", v, 9);
    sync_in = 1'b1;
    @(posedge clk); #1 sync_in = 1'b0;
    @(negedge clk); rd(4'd4, v); check("R11 phase wins", v, 3);
  endtask

  initial begin
    #(100000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_run();
    t_capture();
    t_sync();
    t_pwm();
    t_shadow();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule